// File: doc/BRIEF.md
# Translation Buffer with Access Protection

This block holds a small, fully associative set of page translations for 32-bit virtual addresses split into 4 KiB pages. A lookup request names an address, an access size, a direction (read or write), the privilege level (user or supervisor) and the domain of the running program. One cycle later the block returns either the physical address or a single fault code. The fault code says why the access was refused: the address is misaligned, no translation is present, the page belongs to another domain, or the page's permissions forbid the access.

Each stored translation carries a virtual page number, a physical page number, a 4-bit domain and four 2-bit permission fields, one for each 1 KiB quarter of the page. Translations are loaded through a fill port, which can be driven by an external table walker or by software. A flush input drops every translation at once. When the buffer is full, a new fill evicts an entry in round-robin order.

Top module: `tlbp_top`

## Requirements
- R1: A result appears exactly one clock after the request. `rsp_valid` is high in the cycle after a cycle with `req_valid` high and low otherwise. Reset clears `rsp_valid`.
- R2: Fault codes are 0 for none, 1 for alignment, 2 for translation, 3 for domain and 4 for permission. On fault code 0, `rsp_paddr` is the physical page number of the matching entry in bits 31:12 and the request's address bits 11:0 in bits 11:0. On any fault, `rsp_paddr` is zero.
- R3: Size code 00 is a byte, 01 is a halfword and 10 is a word. A word access with address bits 1:0 not equal to 00, or a halfword access with address bit 0 set, returns fault code 1.
- R4: A lookup whose address bits 31:12 match no valid entry returns fault code 2.
- R5: A lookup that hits an entry whose domain differs from `cur_dom` returns fault code 3.
- R6: Address bits 11:10 select the 2-bit permission field `ap[2s+1:2s]` of subpage s. Field value 00 allows no access. Value 01 allows supervisor read and write only. Value 10 allows supervisor read and write plus user read. Value 11 allows every access. A refused access returns fault code 4.
- R7: Only one fault is reported per lookup, with this priority: alignment first, then translation, then domain, then permission.
- R8: A fill whose page number is already present overwrites that entry. Otherwise the fill goes to the lowest-numbered invalid entry. If every entry is valid, the fill replaces the entry under a round-robin pointer. The pointer starts at entry 0 after reset or flush and advances by one, wrapping, after each replacement.
- R9: An asserted `flush` invalidates every entry within one clock and resets the round-robin pointer to entry 0. When `flush` and `fill_en` are high in the same cycle, the flush takes effect and the fill is dropped.
- R10: A lookup in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_ppn | input | 20 | Physical page number to load |
| fill_dom | input | 4 | Domain of the loaded page |
| fill_ap | input | 8 | Four 2-bit permission fields, subpage 0 in bits 1:0 |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 for write, 0 for read |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| cur_dom | input | 4 | Domain of the running program |
| rsp_valid | output | 1 | Result strobe |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 3 | Fault code |

## Verification
Errors in the stored state show up at the ports on the very next lookup of the affected page. If a fill is written to the wrong slot, a duplicate translation survives. Its physical page number is then merged with the new one, and the corrupted address appears one cycle after the request. If the replacement pointer advances incorrectly, the wrong page is evicted. A lookup of the page that should have been evicted still hits, and a lookup of the page that should remain misses. An incomplete flush also leaves a hit where a translation fault is expected. Permission and domain mistakes appear as a wrong fault code on the first access to the affected subpage.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int DOM_W     = 4;
    localparam int SUB_BITS  = 2;
    localparam int SUBPAGES  = 1 << SUB_BITS;
    localparam int AP_W      = 2 * SUBPAGES;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ALIGN  = 3'd1,
        FLT_XLATE  = 3'd2,
        FLT_DOMAIN = 3'd3,
        FLT_PERM   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] ppn;
        logic [DOM_W-1:0] dom;
        logic [AP_W-1:0]  ap;
    } entry_t;

    function automatic logic misaligned(input logic [1:0] size, input logic [1:0] low);
        case (size)
            SZ_HALF: misaligned = low[0];
            SZ_WORD,
            SZ_RSVD: misaligned = |low;
            default: misaligned = 1'b0;
        endcase
    endfunction

    function automatic logic perm_ok(input logic [1:0] ap2, input logic user, input logic write);
        case (ap2)
            2'b00:   perm_ok = 1'b0;
            2'b01:   perm_ok = !user;
            2'b10:   perm_ok = !user || !write;
            default: perm_ok = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tlbp_store.sv
module tlbp_store
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      fill_en,
    input  logic [VPN_W-1:0]          fill_vpn,
    input  logic [VPN_W-1:0]          fill_ppn,
    input  logic [DOM_W-1:0]          fill_dom,
    input  logic [AP_W-1:0]           fill_ap,
    output entry_t [ENTRIES-1:0]      ents
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] dup_vec;
    logic [ENTRIES-1:0] free_vec;
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   tgt;
    logic               replace;
    logic               found;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_scan
        assign dup_vec[g]  = ents[g].valid && (ents[g].vpn == fill_vpn);
        assign free_vec[g] = !ents[g].valid;
    end

    // Target choice: existing page, then lowest free slot, then round-robin victim.
    always_comb begin
        tgt     = '0;
        replace = 1'b0;
        found   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && dup_vec[i]) begin
                tgt   = IDX_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && free_vec[i]) begin
                tgt   = IDX_W'(i);
                found = 1'b1;
            end
        end
        if (!found) begin
            tgt     = rr_ptr;
            replace = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ents   <= '0;
            rr_ptr <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ents[i].valid <= 1'b0;
            end
            rr_ptr <= '0;
        end else if (fill_en) begin
            ents[tgt] <= '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn,
                           dom: fill_dom, ap: fill_ap};
            if (replace) begin
                rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlbp_match.sv
module tlbp_match
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  entry_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]     vpn,
    output logic [ENTRIES-1:0]   hit_vec,
    output logic                 hit,
    output entry_t               hit_ent
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].valid && (ents[g].vpn == vpn);
    end

    assign hit = |hit_vec;

    // AND-OR select; at most one entry matches a given page.
    always_comb begin
        hit_ent = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_ent = hit_ent | (ents[i] & {$bits(entry_t){hit_vec[i]}});
        end
    end

endmodule

// File: rtl/tlbp_check.sv
module tlbp_check
    import tlbp_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [1:0]       size,
    input  logic             write,
    input  logic             user,
    input  logic [DOM_W-1:0] cur_dom,
    input  logic             hit,
    input  entry_t           hit_ent,
    output fault_e           fault,
    output logic [VA_W-1:0]  paddr
);

    logic [SUB_BITS-1:0] sub;
    logic [1:0]          ap2;

    assign sub = vaddr[OFF_W-1 -: SUB_BITS];
    assign ap2 = hit_ent.ap[2*sub +: 2];

    always_comb begin
        if (misaligned(size, vaddr[1:0])) begin
            fault = FLT_ALIGN;
        end else if (!hit) begin
            fault = FLT_XLATE;
        end else if (hit_ent.dom != cur_dom) begin
            fault = FLT_DOMAIN;
        end else if (!perm_ok(ap2, user, write)) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
    end

    assign paddr = (fault == FLT_NONE) ? {hit_ent.ppn, vaddr[OFF_W-1:0]} : '0;

endmodule

// File: rtl/tlbp_top.sv
module tlbp_top
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        fill_en,
    input  logic [19:0] fill_vpn,
    input  logic [19:0] fill_ppn,
    input  logic [3:0]  fill_dom,
    input  logic [7:0]  fill_ap,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_size,
    input  logic        req_write,
    input  logic        req_user,
    input  logic [3:0]  cur_dom,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic [2:0]  rsp_fault
);

    entry_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0]   hit_vec;
    logic                 hit;
    entry_t               hit_ent;
    fault_e               fault_c;
    logic [VA_W-1:0]      paddr_c;

    tlbp_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .fill_dom (fill_dom),
        .fill_ap  (fill_ap),
        .ents     (ents)
    );

    tlbp_match #(.ENTRIES(ENTRIES)) u_match (
        .ents    (ents),
        .vpn     (req_vaddr[VA_W-1:OFF_W]),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_ent (hit_ent)
    );

    tlbp_check u_check (
        .vaddr   (req_vaddr),
        .size    (req_size),
        .write   (req_write),
        .user    (req_user),
        .cur_dom (cur_dom),
        .hit     (hit),
        .hit_ent (hit_ent),
        .fault   (fault_c),
        .paddr   (paddr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= fault_c;
                rsp_paddr <= paddr_c;
            end
        end
    end

endmodule

// File: rtl/tlbp_checker.sv
module tlbp_checker #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               req_valid,
    input logic [31:0]        req_vaddr,
    input logic [1:0]         req_size,
    input logic               rsp_valid,
    input logic [31:0]        rsp_paddr,
    input logic [2:0]         rsp_fault,
    input logic [ENTRIES-1:0] hit_vec
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r2_offset_passes: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 3'd0) |-> rsp_paddr[11:0] == $past(req_vaddr[11:0]));

    a_r2_zero_on_fault: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == 32'd0);

    a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_fault <= 3'd4);

    a_r3_word_align: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd2 && req_vaddr[1:0] != 2'd0) |=> rsp_fault == 3'd1);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && req_valid && req_size == 2'd0) |=> rsp_fault == 3'd2);

    a_r8_single_hit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

bind tlbp_top tlbp_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .hit_vec   (hit_vec)
);

// File: tb/tlbp_top_tb.sv
module tlbp_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic [3:0]  fill_dom;
    logic [7:0]  fill_ap;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_size;
    logic        req_write;
    logic        req_user;
    logic [3:0]  cur_dom;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_fault;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    tlbp_top #(.ENTRIES(8)) u_dut (
        .clk(clk), .rst(rst), .flush(flush), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dom(fill_dom), .fill_ap(fill_ap),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_size(req_size),
        .req_write(req_write), .req_user(req_user), .cur_dom(cur_dom),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [31:0] va;
        logic [1:0]  sz;
        logic        wr;
        logic        usr;
        logic [3:0]  dom;
        logic [2:0]  ef;
        logic [31:0] ep;
    } vec_t;

    // Page 0x00010: ppn 0x0A000, domain 3, subpage fields 3..0 = 11,10,01,00.
    // Page 0x00020: ppn 0x0B000, domain 5, all subpages 11.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 32'h00010C04, 2'd2, 1'b0, 1'b1, 4'd3, 3'd0, 32'h0A000C04}, // R2 user full subpage
        '{4'd6, 32'h00010004, 2'd2, 1'b0, 1'b0, 4'd3, 3'd4, 32'h0},        // R6 field 00
        '{4'd6, 32'h00010404, 2'd2, 1'b1, 1'b0, 4'd3, 3'd0, 32'h0A000404}, // R6 field 01 sup write
        '{4'd6, 32'h00010404, 2'd2, 1'b0, 1'b1, 4'd3, 3'd4, 32'h0},        // R6 field 01 user
        '{4'd6, 32'h00010804, 2'd2, 1'b0, 1'b1, 4'd3, 3'd0, 32'h0A000804}, // R6 field 10 user read
        '{4'd6, 32'h00010804, 2'd2, 1'b1, 1'b1, 4'd3, 3'd4, 32'h0},        // R6 field 10 user write
        '{4'd3, 32'h00010802, 2'd2, 1'b0, 1'b0, 4'd3, 3'd1, 32'h0},        // R3 word
        '{4'd3, 32'h00010801, 2'd1, 1'b0, 1'b0, 4'd3, 3'd1, 32'h0},        // R3 half
        '{4'd3, 32'h00010803, 2'd0, 1'b0, 1'b1, 4'd3, 3'd0, 32'h0A000803}, // R3 byte any
        '{4'd4, 32'h00030000, 2'd2, 1'b0, 1'b0, 4'd3, 3'd2, 32'h0},        // R4 miss
        '{4'd7, 32'h00030001, 2'd2, 1'b0, 1'b0, 4'd3, 3'd1, 32'h0},        // R7 align over miss
        '{4'd5, 32'h00020000, 2'd2, 1'b0, 1'b0, 4'd3, 3'd3, 32'h0},        // R5 wrong domain
        '{4'd5, 32'h00020000, 2'd2, 1'b1, 1'b1, 4'd5, 3'd0, 32'h0B000000}, // R5 right domain
        '{4'd7, 32'h00010004, 2'd2, 1'b0, 1'b0, 4'd5, 3'd3, 32'h0},        // R7 domain over perm
        '{4'd3, 32'h00010C02, 2'd1, 1'b1, 1'b1, 4'd3, 3'd0, 32'h0A000C02}  // R3 aligned half
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [3:0] dom, input logic [7:0] ap);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_dom = dom; fill_ap = ap;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic lookup(input string tag, input logic [31:0] va, input logic [1:0] sz,
                          input logic wr, input logic usr, input logic [3:0] dom,
                          input logic [2:0] ef, input logic [31:0] ep);
        req_valid = 1'b1; req_vaddr = va; req_size = sz;
        req_write = wr; req_user = usr; cur_dom = dom;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " fault"}, {29'd0, rsp_fault}, {29'd0, ef});
        check({tag, " paddr"}, rsp_paddr, ep);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; flush = 1'b0; fill_en = 1'b0; fill_vpn = '0; fill_ppn = '0;
        fill_dom = '0; fill_ap = '0; req_valid = 1'b0; req_vaddr = '0; req_size = '0;
        req_write = 1'b0; req_user = 1'b0; cur_dom = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // R4: empty after reset
        lookup("R4 empty", 32'h00010000, 2'd2, 1'b0, 1'b0, 4'd3, 3'd2, 32'h0);

        fill(20'h00010, 20'h0A000, 4'd3, 8'b11_10_01_00);
        fill(20'h00020, 20'h0B000, 4'd5, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            lookup($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].va, VECS[i].sz,
                   VECS[i].wr, VECS[i].usr, VECS[i].dom, VECS[i].ef, VECS[i].ep);
        end
        @(negedge clk);
        check("R1 valid drops", {31'd0, rsp_valid}, 32'd0);

        // R8: refill of a present page overwrites it in place
        fill(20'h00010, 20'h0C000, 4'd3, 8'hFF);
        lookup("R8 overwrite", 32'h00010004, 2'd2, 1'b1, 1'b1, 4'd3, 3'd0, 32'h0C000004);
        lookup("R8 other kept", 32'h00020010, 2'd2, 1'b0, 1'b0, 4'd5, 3'd0, 32'h0B000010);

        // R10: lookup concurrent with fill sees old contents
        req_valid = 1'b1; req_vaddr = 32'h00040008; req_size = 2'd2;
        req_write = 1'b0; req_user = 1'b0; cur_dom = 4'd1;
        fill_en = 1'b1; fill_vpn = 20'h00040; fill_ppn = 20'h0D000; fill_dom = 4'd1; fill_ap = 8'hFF;
        @(negedge clk);
        fill_en = 1'b0; req_valid = 1'b0;
        check("R10 same-cycle fault", {29'd0, rsp_fault}, 32'd2);
        lookup("R10 after fill", 32'h00040008, 2'd2, 1'b0, 1'b0, 4'd1, 3'd0, 32'h0D000008);

        // R9: flush with a simultaneous fill
        flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00050; fill_ppn = 20'h0E000;
        fill_dom = 4'd1; fill_ap = 8'hFF;
        @(negedge clk);
        flush = 1'b0; fill_en = 1'b0;
        lookup("R9 flushed", 32'h00020000, 2'd0, 1'b0, 1'b0, 4'd5, 3'd2, 32'h0);
        lookup("R9 fill dropped", 32'h00050000, 2'd0, 1'b0, 1'b0, 4'd1, 3'd2, 32'h0);

        // R8: round-robin replacement after filling all eight entries
        for (int i = 0; i < 8; i++) begin
            fill(20'h00100 + 20'(i), 20'h20000 + 20'(i), 4'd2, 8'hFF);
        end
        lookup("R8 full hit7", 32'h00107000, 2'd2, 1'b0, 1'b0, 4'd2, 3'd0, 32'h20007000);
        fill(20'h00108, 20'h20008, 4'd2, 8'hFF);
        lookup("R8 victim0 gone", 32'h00100000, 2'd2, 1'b0, 1'b0, 4'd2, 3'd2, 32'h0);
        lookup("R8 entry1 kept", 32'h00101000, 2'd2, 1'b0, 1'b0, 4'd2, 3'd0, 32'h20001000);
        lookup("R8 new hit", 32'h00108000, 2'd2, 1'b0, 1'b0, 4'd2, 3'd0, 32'h20008000);
        fill(20'h00109, 20'h20009, 4'd2, 8'hFF);
        lookup("R8 victim1 gone", 32'h00101000, 2'd2, 1'b0, 1'b0, 4'd2, 3'd2, 32'h0);
        lookup("R8 entry2 kept", 32'h00102000, 2'd2, 1'b0, 1'b0, 4'd2, 3'd0, 32'h20002000);

        // R9: flush resets the pointer; refill from empty then one replacement
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 9; i++) begin
            fill(20'h00200 + 20'(i), 20'h30000 + 20'(i), 4'd2, 8'hFF);
        end
        lookup("R9 ptr reset victim0", 32'h00200000, 2'd2, 1'b0, 1'b0, 4'd2, 3'd2, 32'h0);
        lookup("R9 ptr reset entry1", 32'h00201000, 2'd2, 1'b0, 1'b0, 4'd2, 3'd0, 32'h30001000);

        @(negedge clk);
        finish_run();
    end

endmodule